// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block provides doorbell signalling between the two ports of a shared dual-port memory. Two words at the very top of the address space act as mailboxes, one for each direction. When one port writes its outgoing mailbox word, the block raises an interrupt towards the opposite port. That interrupt stays raised until the receiving port reads the same word. The words themselves are ordinary memory locations. Their contents are whatever the software puts there, and they are stored in the main array, not here.

The block sees one completed access per port per clock cycle. For each port it receives a select, a write/read direction and the address. It drives one active-low interrupt per port, and each interrupt output is driven both high and low. The address width is a parameter. The right-bound mailbox is always the highest address and the left-bound mailbox sits one below it.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset both interrupt outputs are high, meaning inactive.
- R2: A left-port write (select=1, write=1) to the highest address (all ones, 0x3FFF at the default 14-bit width) drives `r_irq_n` low from the next clock cycle.
- R3: A right-port read (select=1, write=0) of the highest address returns `r_irq_n` high from the next cycle.
- R4: A right-port write to the address one below the highest (0x3FFE by default) drives `l_irq_n` low from the next cycle.
- R5: A left-port read of the address one below the highest returns `l_irq_n` high from the next cycle.
- R6: An access counts only while its port's select is 1. Writes to any non-mailbox address and cycles with select=0 leave both outputs unchanged.
- R7: If one flag is set and cleared in the same cycle, the set wins and the interrupt is low afterwards.
- R8: A port that writes its own incoming mailbox address, or reads its own outgoing mailbox address, leaves both interrupts unchanged.
- R9: A raised interrupt stays low through idle cycles and through repeated sets until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port access valid this cycle |
| l_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| l_addr | input | ADDR_W | Left port address |
| r_sel | input | 1 | Right port access valid this cycle |
| r_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| r_addr | input | ADDR_W | Right port address |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
Each direction is exercised with a matched set and clear. Wrong-direction accesses to each mailbox word are also applied; these show that the decode checks the direction and the port, not only the address. Non-mailbox writes and unselected cycles are applied while a flag is set and while it is clear, so that a stray set and a stray clear are both visible. Simultaneous set and clear of the same flag, and simultaneous doorbells from both ports, show the priority rule and show that the two flags are independent.

// File: rtl/mbx_doorbell_pkg.sv
package mbx_doorbell_pkg;
   localparam int NUM_PORTS = 2;

   typedef enum logic {
      PORT_L = 1'b0,
      PORT_R = 1'b1
   } port_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int              ADDR_W   = 14,
   parameter logic [ADDR_W-1:0] OUT_ADDR = '1,
   parameter logic [ADDR_W-1:0] IN_ADDR  = '0
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ring_o,
   output logic              ack_o
);
   generate
      if (OUT_ADDR == IN_ADDR) begin : g_bad_map
         $error("mbx_decode: mailbox addresses must differ");
      end
   endgenerate

   always_comb begin
      ring_o = sel_i &  wr_i & (addr_i == OUT_ADDR);
      ack_o  = sel_i & ~wr_i & (addr_i == IN_ADDR);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   // R7: set has priority over a simultaneous clear
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R3 / R5: a lone clear drops the flag
   a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   // R9: no event, no change
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
   import mbx_doorbell_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_sel,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_irq_n,
   output logic              r_irq_n
);
   localparam logic [ADDR_W-1:0] TO_RIGHT = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] TO_LEFT  = TO_RIGHT - 1'b1;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("mbx_doorbell: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic [NUM_PORTS-1:0] sel_v, wr_v, ring_v, ack_v, flag_v;
   logic [ADDR_W-1:0]    addr_v [NUM_PORTS];

   always_comb begin
      sel_v[PORT_L]  = l_sel;
      wr_v[PORT_L]   = l_wr;
      addr_v[PORT_L] = l_addr;
      sel_v[PORT_R]  = r_sel;
      wr_v[PORT_R]   = r_wr;
      addr_v[PORT_R] = r_addr;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] OUT_A = (p == 0) ? TO_RIGHT : TO_LEFT;
      localparam logic [ADDR_W-1:0] IN_A  = (p == 0) ? TO_LEFT  : TO_RIGHT;

      mbx_decode #(
         .ADDR_W  (ADDR_W),
         .OUT_ADDR(OUT_A),
         .IN_ADDR (IN_A)
      ) u_dec (
         .sel_i (sel_v[p]),
         .wr_i  (wr_v[p]),
         .addr_i(addr_v[p]),
         .ring_o(ring_v[p]),
         .ack_o (ack_v[p])
      );

      mbx_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ring_v[NUM_PORTS-1-p]),
         .clr_i (ack_v[p]),
         .flag_o(flag_v[p])
      );
   end

   assign l_irq_n = ~flag_v[PORT_L];
   assign r_irq_n = ~flag_v[PORT_R];

   // R2: left doorbell write raises the right interrupt
   a_r2_left_rings: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && l_wr && l_addr == TO_RIGHT) |=> !r_irq_n);
   // R4: right doorbell write raises the left interrupt
   a_r4_right_rings: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sel && r_wr && r_addr == TO_LEFT) |=> !l_irq_n);
   // R3: right read of its mailbox with no competing set releases r_irq_n
   a_r3_right_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (r_sel && !r_wr && r_addr == TO_RIGHT &&
       !(l_sel && l_wr && l_addr == TO_RIGHT)) |=> r_irq_n);
   // R5: left read of its mailbox with no competing set releases l_irq_n
   a_r5_left_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && !l_wr && l_addr == TO_LEFT &&
       !(r_sel && r_wr && r_addr == TO_LEFT)) |=> l_irq_n);
   // R8: left writing its own incoming mailbox leaves l_irq_n alone
   a_r8_left_self_write: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel && l_wr && l_addr == TO_LEFT &&
       !(r_sel && r_wr && r_addr == TO_LEFT)) |=> $stable(l_irq_n));
   // R6: idle cycle on both ports changes nothing
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sel && !r_sel) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
endmodule

// File: tb/mbx_doorbell_tb.sv
module mbx_doorbell_tb;
   localparam int AW = 14;
   localparam logic [AW-1:0] A_TOP = 14'h3FFF;
   localparam logic [AW-1:0] A_LOW = 14'h3FFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel = 0, l_wr = 0, r_sel = 0, r_wr = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mbx_doorbell #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr),
      .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one access cycle on both ports, then idle; outputs sampled after the edge
   task automatic cyc(input logic ls, input logic lw, input logic [AW-1:0] la,
                      input logic rs, input logic rw, input logic [AW-1:0] ra);
      @(negedge clk);
      l_sel = ls; l_wr = lw; l_addr = la;
      r_sel = rs; r_wr = rw; r_addr = ra;
      @(negedge clk);
      l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
      #0.5;
   endtask

   task automatic both(input string tag, input logic el, input logic er);
      check({tag, " l_irq_n"}, l_irq_n, el);
      check({tag, " r_irq_n"}, r_irq_n, er);
   endtask

   task automatic t_reset;
      both("R1 reset", 1, 1);
   endtask

   task automatic t_left_to_right;
      cyc(1, 1, A_TOP, 0, 0, '0);  both("R2 left ring", 1, 0);
      cyc(1, 1, A_TOP, 0, 0, '0);  both("R9 repeat set", 1, 0);
      repeat (5) @(negedge clk);
      #0.5;                        both("R9 idle hold", 1, 0);
      cyc(1, 0, A_TOP, 0, 0, '0);  both("R8 left reads outgoing", 1, 0);
      cyc(0, 0, '0, 1, 0, A_LOW);  both("R8 right reads outgoing", 1, 0);
      cyc(0, 0, '0, 1, 0, A_TOP);  both("R3 right ack", 1, 1);
   endtask

   task automatic t_right_to_left;
      cyc(1, 1, A_LOW, 0, 0, '0);  both("R8 left writes incoming", 1, 1);
      cyc(0, 0, '0, 1, 1, A_TOP);  both("R8 right writes incoming", 1, 1);
      cyc(0, 0, '0, 1, 1, A_LOW);  both("R4 right ring", 0, 1);
      cyc(1, 0, A_LOW, 0, 0, '0);  both("R5 left ack", 1, 1);
   endtask

   task automatic t_qualify;
      cyc(0, 1, A_TOP, 0, 1, A_LOW);     both("R6 unselected writes", 1, 1);
      cyc(1, 1, 14'h3FFD, 1, 1, 14'h0000); both("R6 other addresses", 1, 1);
      cyc(1, 1, A_TOP, 1, 1, A_LOW);     both("R6 setup both set", 0, 0);
      cyc(0, 0, A_LOW, 0, 0, A_TOP);     both("R6 unselected reads", 0, 0);
      cyc(1, 1, 14'h1FFF, 1, 0, 14'h3FFC); both("R6 near miss", 0, 0);
      cyc(1, 0, A_LOW, 1, 0, A_TOP);     both("R3 R5 joint ack", 1, 1);
   endtask

   task automatic t_collide;
      cyc(1, 1, A_TOP, 1, 0, A_TOP);  both("R7 set+clear from clear", 1, 0);
      cyc(1, 1, A_TOP, 1, 0, A_TOP);  both("R7 set+clear while set", 1, 0);
      cyc(1, 0, A_LOW, 1, 1, A_LOW);  both("R7 left set+clear", 0, 0);
      cyc(1, 0, A_LOW, 1, 0, A_TOP);  both("R7 release both", 1, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #0.5;
      t_reset();
      rst_n = 1'b1;
      t_left_to_right();
      t_right_to_left();
      t_qualify();
      t_collide();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule